// File: doc/BRIEF.md
# Processor Status Word Register

This block keeps the status word of a small processor core. It captures the condition flags left by the last flag-setting ALU operation: zero, sign, carry and overflow. A compare strobe separately records whether two operands were equal. The word also holds an interrupt-enable bit and a privilege bit. The privilege bit is handled by a two-state mode machine with the states `MODE_SUPER` and `MODE_USER`. The transition `SUPER_TO_USER` happens when supervisor software writes the word with the privilege bit clear. The transition `USER_TO_SUPER` happens only on an exception-entry strobe. Both states hold otherwise: `SUPER_HOLD` and `USER_HOLD`.

Software may overwrite the whole word through a write port, but only while in supervisor mode. A write issued from user mode is dropped in full. An exception-entry strobe forces supervisor mode and masks interrupts in the same edge, and it overrides a software write issued in that same cycle. A combinational condition evaluator turns a 3-bit selector into a branch-taken signal from the stored flags. Conditional branches read the flags only through that signal.

Top module: `psw_reg`

## Requirements
- R1: After reset all flags and the interrupt-enable bit read 0 and the supervisor bit reads 1.
- R2: When `flag_upd` is high and no software write is accepted, on the next edge zero becomes (result == 0), sign becomes the result MSB, and carry and overflow take `alu_carry` and `alu_overflow`.
- R3: When `cmp_strobe` is high and no software write is accepted, on the next edge the equal flag becomes (`cmp_a` == `cmp_b`).
- R4: Without `flag_upd` the zero, sign, carry and overflow flags keep their values. Without `cmp_strobe` the equal flag keeps its value, unless a software write is accepted.
- R5: A software write issued while in user mode changes no field.
- R6: A software write in supervisor mode without `exc_entry` loads every field from `sw_wr_data`, using the bit positions 0 zero, 1 sign, 2 carry, 3 overflow, 4 equal, 5 interrupt enable, 6 supervisor. It takes priority over `flag_upd` and `cmp_strobe` in the same cycle.
- R7: `exc_entry` sets supervisor to 1 and interrupt enable to 0 on the next edge. A software write in that cycle is discarded.
- R8: The supervisor bit can go from 0 to 1 only through `exc_entry`.
- R9: `cond_taken` follows `cond_sel` combinationally with the encodings 0 zero, 1 not zero, 2 carry, 3 sign, 4 overflow, 5 equal, 6 always, 7 never.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_result | input | DATA_W | Result of the current ALU operation |
| alu_carry | input | 1 | Carry out of the ALU |
| alu_overflow | input | 1 | Signed overflow of the ALU |
| flag_upd | input | 1 | Capture zero/sign/carry/overflow from the ALU |
| cmp_strobe | input | 1 | Capture equality of the compare operands |
| cmp_a | input | DATA_W | First compare operand |
| cmp_b | input | DATA_W | Second compare operand |
| sw_wr_en | input | 1 | Software write request |
| sw_wr_data | input | 7 | Software write value (layout in R6) |
| exc_entry | input | 1 | Exception-entry strobe |
| cond_sel | input | 3 | Branch condition selector (R9) |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |
| flag_equal | output | 1 | Equal flag |
| int_en | output | 1 | Interrupt enable |
| super_mode | output | 1 | Supervisor mode |
| cond_taken | output | 1 | Selected condition is true |

## Verification
A wrong mode state appears at the `super_mode` port on the edge after the faulty transition. It also shows one cycle later as writes that are either lost or wrongly accepted. A corrupted flag register shows at its flag output right after the edge that loaded it, and within the same cycle on `cond_taken` for any selector naming that flag. Faulty priority between exception, write and ALU strobes shows as a single-cycle mismatch in the fields involved. The stimulus therefore compares every output against a model after each clock.

// File: rtl/psw_pkg.sv
package psw_pkg;

    localparam int PSW_W = 7;

    typedef enum logic [0:0] {
        MODE_USER  = 1'b0,
        MODE_SUPER = 1'b1
    } priv_mode_e;

    typedef enum logic [2:0] {
        COND_ZERO   = 3'd0,
        COND_NZERO  = 3'd1,
        COND_CARRY  = 3'd2,
        COND_SIGN   = 3'd3,
        COND_OVF    = 3'd4,
        COND_EQUAL  = 3'd5,
        COND_ALWAYS = 3'd6,
        COND_NEVER  = 3'd7
    } cond_code_e;

    // bit 6 .. bit 0
    typedef struct packed {
        logic super_b;
        logic ie;
        logic equal;
        logic ovf;
        logic carry;
        logic sign;
        logic zero;
    } psw_image_t;

    typedef struct packed {
        logic equal;
        logic ovf;
        logic carry;
        logic sign;
        logic zero;
    } cond_flags_t;

endpackage

// File: rtl/psw_mode_ctrl.sv
module psw_mode_ctrl
    import psw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic exc_entry,
    input  logic sw_wr_en,
    input  logic wr_super,
    input  logic wr_ie,
    output logic wr_accept,
    output logic super_mode,
    output logic int_en
);

    priv_mode_e state_q, state_d;
    logic       ie_q, ie_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SUPER: begin
                if (!exc_entry && sw_wr_en && !wr_super)
                    state_d = MODE_USER;        // SUPER_TO_USER
                else
                    state_d = MODE_SUPER;       // SUPER_HOLD
            end
            MODE_USER: begin
                if (exc_entry)
                    state_d = MODE_SUPER;       // USER_TO_SUPER
                else
                    state_d = MODE_USER;        // USER_HOLD
            end
            default: state_d = MODE_SUPER;
        endcase
    end

    always_comb begin
        wr_accept = (state_q == MODE_SUPER) && sw_wr_en && !exc_entry;
        if (exc_entry)
            ie_d = 1'b0;
        else if (wr_accept)
            ie_d = wr_ie;
        else
            ie_d = ie_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= MODE_SUPER;
            ie_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ie_q    <= ie_d;
        end
    end

    always_comb begin
        super_mode = (state_q == MODE_SUPER);
        int_en     = ie_q;
    end

    assert_exc_forces_super_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_entry |=> (super_mode && !int_en));

    assert_no_user_escape_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!super_mode && !exc_entry) |=> !super_mode);

    assert_user_ie_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!super_mode && !exc_entry) |=> $stable(int_en));

endmodule

// File: rtl/psw_flag_bank.sv
module psw_flag_bank
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_overflow,
    input  logic              flag_upd,
    input  logic              cmp_strobe,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              wr_accept,
    input  cond_flags_t       wr_flags,
    output cond_flags_t       flags
);

    localparam int MSB = DATA_W - 1;

    cond_flags_t flags_q, flags_d;
    logic        res_is_zero;
    logic        ops_match;

    always_comb begin
        res_is_zero = ~|alu_result;
        ops_match   = (cmp_a == cmp_b);
    end

    always_comb begin
        flags_d = flags_q;
        if (wr_accept) begin
            flags_d = wr_flags;
        end else begin
            if (flag_upd) begin
                flags_d.zero  = res_is_zero;
                flags_d.sign  = alu_result[MSB];
                flags_d.carry = alu_carry;
                flags_d.ovf   = alu_overflow;
            end
            if (cmp_strobe)
                flags_d.equal = ops_match;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;

    assert_zero_tracks_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_upd && !wr_accept) |=> (flags.zero == ($past(alu_result) == '0)));

    assert_equal_tracks_cmp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_strobe && !wr_accept) |=> (flags.equal == ($past(cmp_a) == $past(cmp_b))));

    assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_upd && !cmp_strobe && !wr_accept) |=> $stable(flags));

    assert_write_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_accept |=> (flags == $past(wr_flags)));

endmodule

// File: rtl/psw_cond_eval.sv
module psw_cond_eval
    import psw_pkg::*;
(
    input  cond_flags_t flags,
    input  logic [2:0]  cond_sel,
    output logic        cond_taken
);

    cond_code_e code;

    always_comb begin
        code = cond_code_e'(cond_sel);
        unique case (code)
            COND_ZERO:   cond_taken = flags.zero;
            COND_NZERO:  cond_taken = !flags.zero;
            COND_CARRY:  cond_taken = flags.carry;
            COND_SIGN:   cond_taken = flags.sign;
            COND_OVF:    cond_taken = flags.ovf;
            COND_EQUAL:  cond_taken = flags.equal;
            COND_ALWAYS: cond_taken = 1'b1;
            COND_NEVER:  cond_taken = 1'b0;
            default:     cond_taken = 1'b0;
        endcase
    end

endmodule

// File: rtl/psw_reg.sv
module psw_reg
    import psw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_overflow,
    input  logic              flag_upd,
    input  logic              cmp_strobe,
    input  logic [DATA_W-1:0] cmp_a,
    input  logic [DATA_W-1:0] cmp_b,
    input  logic              sw_wr_en,
    input  logic [6:0]        sw_wr_data,
    input  logic              exc_entry,
    input  logic [2:0]        cond_sel,
    output logic              flag_zero,
    output logic              flag_sign,
    output logic              flag_carry,
    output logic              flag_ovf,
    output logic              flag_equal,
    output logic              int_en,
    output logic              super_mode,
    output logic              cond_taken
);

    psw_image_t  wr_img;
    cond_flags_t wr_flags;
    cond_flags_t flags;
    logic        wr_accept;

    always_comb begin
        wr_img         = psw_image_t'(sw_wr_data);
        wr_flags.zero  = wr_img.zero;
        wr_flags.sign  = wr_img.sign;
        wr_flags.carry = wr_img.carry;
        wr_flags.ovf   = wr_img.ovf;
        wr_flags.equal = wr_img.equal;
    end

    psw_mode_ctrl u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .exc_entry  (exc_entry),
        .sw_wr_en   (sw_wr_en),
        .wr_super   (wr_img.super_b),
        .wr_ie      (wr_img.ie),
        .wr_accept  (wr_accept),
        .super_mode (super_mode),
        .int_en     (int_en)
    );

    psw_flag_bank #(.DATA_W(DATA_W)) u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .alu_result   (alu_result),
        .alu_carry    (alu_carry),
        .alu_overflow (alu_overflow),
        .flag_upd     (flag_upd),
        .cmp_strobe   (cmp_strobe),
        .cmp_a        (cmp_a),
        .cmp_b        (cmp_b),
        .wr_accept    (wr_accept),
        .wr_flags     (wr_flags),
        .flags        (flags)
    );

    psw_cond_eval u_cond (
        .flags      (flags),
        .cond_sel   (cond_sel),
        .cond_taken (cond_taken)
    );

    always_comb begin
        flag_zero  = flags.zero;
        flag_sign  = flags.sign;
        flag_carry = flags.carry;
        flag_ovf   = flags.ovf;
        flag_equal = flags.equal;
    end

    assert_user_write_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!super_mode && !exc_entry && !flag_upd && !cmp_strobe) |=>
            ($stable({flag_zero, flag_sign, flag_carry, flag_ovf, flag_equal, int_en, super_mode})));

    assert_super_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(super_mode) |-> $past(exc_entry));

    assert_always_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd6) |-> cond_taken);

    assert_never_taken_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_sel == 3'd7) |-> !cond_taken);

endmodule

// File: tb/psw_reg_tb_top.sv
module psw_reg_tb_top;

    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [DW-1:0] alu_result, cmp_a, cmp_b;
    logic          alu_carry, alu_overflow, flag_upd, cmp_strobe;
    logic          sw_wr_en, exc_entry;
    logic [6:0]    sw_wr_data;
    logic [2:0]    cond_sel;
    logic          flag_zero, flag_sign, flag_carry, flag_ovf, flag_equal;
    logic          int_en, super_mode, cond_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // model state, bit layout as R6
    logic [6:0] m;

    always #10 clk = ~clk;

    psw_reg #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .alu_result(alu_result), .alu_carry(alu_carry), .alu_overflow(alu_overflow),
        .flag_upd(flag_upd), .cmp_strobe(cmp_strobe), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .exc_entry(exc_entry),
        .cond_sel(cond_sel),
        .flag_zero(flag_zero), .flag_sign(flag_sign), .flag_carry(flag_carry),
        .flag_ovf(flag_ovf), .flag_equal(flag_equal), .int_en(int_en),
        .super_mode(super_mode), .cond_taken(cond_taken)
    );

    function automatic logic [6:0] model_next(input logic [6:0] s);
        logic [6:0] n;
        logic       acc;
        n   = s;
        acc = s[6] && sw_wr_en && !exc_entry;
        if (acc) begin
            n = sw_wr_data;
        end else begin
            if (flag_upd) begin
                n[0] = (alu_result == '0);
                n[1] = alu_result[DW-1];
                n[2] = alu_carry;
                n[3] = alu_overflow;
            end
            if (cmp_strobe) n[4] = (cmp_a == cmp_b);
        end
        if (exc_entry) begin
            n[6] = 1'b1;
            n[5] = 1'b0;
        end
        return n;
    endfunction

    function automatic logic model_cond(input logic [6:0] s, input logic [2:0] sel);
        case (sel)
            3'd0: return s[0];
            3'd1: return !s[0];
            3'd2: return s[2];
            3'd3: return s[1];
            3'd4: return s[3];
            3'd5: return s[4];
            3'd6: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [6:0] dut_word();
        return {super_mode, int_en, flag_equal, flag_ovf, flag_carry, flag_sign, flag_zero};
    endfunction

    task automatic idle_inputs();
        alu_result = '0; alu_carry = 0; alu_overflow = 0;
        flag_upd = 0; cmp_strobe = 0; cmp_a = '0; cmp_b = '0;
        sw_wr_en = 0; sw_wr_data = '0; exc_entry = 0; cond_sel = 3'd6;
    endtask

    // at negedge: inputs already set; advance one edge, then compare the whole word
    task automatic step(input string req);
        m = model_next(m);
        @(posedge clk);
        @(negedge clk);
        check(req, {1'b0, dut_word()}, {1'b0, m});
        for (int k = 0; k < 8; k++) begin
            cond_sel = 3'(k);
            #1;
            check("R9", {7'b0, cond_taken}, {7'b0, model_cond(m, 3'(k))});
        end
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        m = 7'b100_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R1", {1'b0, dut_word()}, 8'h40);

        // R2: zero result sets zero flag
        flag_upd = 1; alu_result = '0; alu_carry = 1;
        step("R2");
        // R2: negative result sets sign
        idle_inputs(); flag_upd = 1; alu_result = 16'h8001; alu_overflow = 1;
        step("R2");
        // R3: equal compare
        idle_inputs(); cmp_strobe = 1; cmp_a = 16'h1234; cmp_b = 16'h1234;
        step("R3");
        // R4: no strobes, flags hold
        idle_inputs(); alu_result = 16'h0005;
        step("R4");
        // R6: supervisor write with flag_upd in same cycle, enter user mode
        idle_inputs(); sw_wr_en = 1; sw_wr_data = 7'b010_1010; flag_upd = 1; alu_result = '0;
        step("R6");
        // R5: user write ignored, including attempt to set supervisor
        idle_inputs(); sw_wr_en = 1; sw_wr_data = 7'b111_1111;
        step("R5");
        // R8: still user after idle
        idle_inputs();
        step("R8");
        // R7: exception with write in same cycle from user
        idle_inputs(); exc_entry = 1; sw_wr_en = 1; sw_wr_data = 7'b011_1111;
        step("R7");
        // R6: supervisor sets ie while staying supervisor
        idle_inputs(); sw_wr_en = 1; sw_wr_data = 7'b111_0101;
        step("R6");
        // R7: exception while supervisor with write, write discarded
        idle_inputs(); exc_entry = 1; sw_wr_en = 1; sw_wr_data = 7'b010_0000;
        step("R7");

        // constrained random
        for (int i = 0; i < 3000; i++) begin
            idle_inputs();
            alu_result   = ($urandom % 4 == 0) ? '0 : DW'($urandom);
            alu_carry    = 1'($urandom);
            alu_overflow = 1'($urandom);
            flag_upd     = ($urandom % 2) == 0;
            cmp_strobe   = ($urandom % 3) == 0;
            cmp_a        = DW'($urandom % 4);
            cmp_b        = DW'($urandom % 4);
            sw_wr_en     = ($urandom % 4) == 0;
            sw_wr_data   = 7'($urandom);
            exc_entry    = ($urandom % 16) == 0;
            step(exc_entry ? "R7" : (sw_wr_en ? (m[6] ? "R6" : "R5") : "R2"));
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule